// File: doc/BRIEF.md
# MSI-X Capability Register with Pending-Vector Rescan

This block holds the MSI-X capability structure that sits in a function's PCI configuration space. The structure is three dwords. The first dword carries the capability identifier, the link to the next capability and the message control word. The second and third dwords give where the vector table and the pending-bit array live inside a memory BAR. Configuration writes arrive as a starting byte offset inside the structure, a length of one to four bytes and a little-endian data word. The block walks the bytes in order and drops every byte that lands on a read-only field. The only writable state is the global enable bit and the function mask bit of the message control word. Both are exported as registered outputs.

A write can unmask the function (the mask goes from 1 to 0) or switch the function on (the enable goes from 0 to 1). Either event starts a sequencer. It examines one vector per cycle, from vector 0 up to the last vector. For every vector whose pending flag is set and whose per-vector mask is clear, it raises a one-cycle delivery request carrying the vector number. The vector table and the message path are outside the block. The per-vector pending and mask flags come in as plain inputs.

Top module: `msixcap_rescan`

## Requirements
- R1: A synchronous active-high reset leaves the enable, function mask, scan busy flag and delivery request all at 0. A reset during a scan stops the scan.
- R2: A read of dword index 0 returns its data one cycle after the index is sampled. Bits 7:0 hold CAP_ID (default 0x11) and bits 15:8 hold NEXT_PTR. Bits 26:16 hold NUM_VEC-1, bits 29:27 read 0, bit 30 is the function mask and bit 31 is the enable.
- R3: Dword index 1 reads BAR_IDX, which means a table offset of 0. Dword index 2 reads (NUM_VEC*16) | BAR_IDX. Index 3 reads 0. BAR_IDX must lie in 0..5.
- R4: Write bytes at offsets 0, 1, 2 and 4 to 11 have no effect on any read-back value or output.
- R5: A byte written at offset 3 sets the enable from its bit 7 and the function mask from its bit 6. Its bits 5:0 are ignored.
- R6: A write of length L (1..4) at offset O applies data bits [8i+7:8i] to offset O+i for each i < L. Offsets beyond 11 are dropped.
- R7: A write that takes the function mask from 1 to 0 raises scan busy in the next cycle. On a scan that does not restart, busy stays high for exactly NUM_VEC cycles.
- R8: A write that takes the enable from 0 to 1 starts the same scan. No other write starts a scan, whether it sets the mask, clears the enable or changes nothing.
- R9: A scan examines vectors in ascending order, one per cycle. It raises the delivery request, for one cycle, with the vector number only for vectors that are pending and not individually masked.
- R10: A scan trigger that arrives while a scan is running, including on its last vector, makes the scan continue from vector 0 without busy dropping. Any number of such triggers during one pass cause a single extra pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_off | input | 4 | Byte offset of the first written byte inside the capability |
| wr_len | input | 3 | Number of bytes written, 1 to 4 |
| wr_data | input | 32 | Write data, lane i in bits [8i+7:8i] |
| rd_sel | input | 2 | Dword index to read |
| rd_data | output | 32 | Registered read data |
| vec_pending | input | NUM_VEC | Per-vector pending flags |
| vec_masked | input | NUM_VEC | Per-vector mask flags |
| msix_enable | output | 1 | Global enable |
| func_mask | output | 1 | Function mask |
| scan_busy | output | 1 | Rescan in progress |
| deliver_req | output | 1 | One-cycle delivery request |
| deliver_vec | output | VEC_W | Vector number of the request |

## Verification
The bench builds the block with six vectors, BAR index 3 and a next pointer of 0x40, so every read-back field differs from its default and from the others. The pending-array dword becomes 0x63. With six vectors a scan lasts only six cycles. That makes the restart cases reachable: a trigger in the middle of a pass, and a trigger that lands exactly on the last vector. A mix of pending and individually masked vectors shows both delivered and suppressed vectors in one pass.

// File: rtl/msixcap_pkg.sv
package msixcap_pkg;
  localparam int CAP_BYTES   = 12;
  localparam int CTRL_HI_OFF = 3;
  localparam int LANES       = 4;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_t;
endpackage

// File: rtl/msixcap_wr_lanes.sv
module msixcap_wr_lanes
  import msixcap_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int LEN_W = 3
) (
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     wr_off,
  input  logic [LEN_W-1:0]     wr_len,
  input  logic [8*LANES-1:0]   wr_data,
  output logic                 hi_we,
  output logic [7:0]           hi_byte
);
  localparam int SUM_W = OFF_W + 1;

  logic [LANES-1:0] lane_hit;

  // each lane lands at wr_off + i; only the control high byte is writable
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      lane_hit[i] = wr_en
                 && (LEN_W'(i) < wr_len)
                 && (({1'b0, wr_off} + SUM_W'(i)) == SUM_W'(CTRL_HI_OFF));
    end
  end

  always_comb begin
    hi_we   = |lane_hit;
    hi_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_hit[i]) hi_byte = wr_data[8*i +: 8];
    end
  end
endmodule

// File: rtl/msixcap_ctrl_reg.sv
module msixcap_ctrl_reg #(
  parameter int       NUM_VEC  = 8,
  parameter int       BAR_IDX  = 0,
  parameter bit [7:0] NEXT_PTR = 8'h00,
  parameter bit [7:0] CAP_ID   = 8'h11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hi_we,
  input  logic [7:0]  hi_byte,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        enable,
  output logic        fmask,
  output logic        scan_trig
);
  localparam logic [10:0] TSIZE   = 11'(NUM_VEC - 1);
  localparam logic [31:0] TBL_DW  = 32'(BAR_IDX);
  localparam logic [31:0] PBA_DW  = 32'(NUM_VEC * 16) | 32'(BAR_IDX);

  // unmask (1->0) or switch-on (0->1) asks for a rescan
  always_comb begin
    scan_trig = hi_we && ((fmask && !hi_byte[6]) || (!enable && hi_byte[7]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      fmask  <= 1'b0;
    end else if (hi_we) begin
      enable <= hi_byte[7];
      fmask  <= hi_byte[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        2'd0:    rd_data <= {enable, fmask, 3'b000, TSIZE, NEXT_PTR, CAP_ID};
        2'd1:    rd_data <= TBL_DW;
        2'd2:    rd_data <= PBA_DW;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/msixcap_scan.sv
module msixcap_scan
  import msixcap_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [NUM_VEC-1:0] vmask,
  output logic               busy,
  output logic               del_req,
  output logic [VEC_W-1:0]   del_vec
);
  localparam logic [VEC_W-1:0] LAST = VEC_W'(NUM_VEC - 1);

  scan_state_t      state;
  logic [VEC_W-1:0] idx;
  logic             again;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SC_IDLE;
      idx     <= '0;
      again   <= 1'b0;
      del_req <= 1'b0;
      del_vec <= '0;
    end else begin
      del_req <= 1'b0;
      case (state)
        SC_IDLE: begin
          if (trig) begin
            state <= SC_RUN;
            idx   <= '0;
            again <= 1'b0;
          end
        end
        SC_RUN: begin
          del_req <= pend[idx] & ~vmask[idx];
          del_vec <= idx;
          if (idx == LAST) begin
            idx   <= '0;
            again <= 1'b0;
            if (!(again || trig)) state <= SC_IDLE;
          end else begin
            idx <= idx + 1'b1;
            if (trig) again <= 1'b1;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  always_comb busy = (state == SC_RUN);
endmodule

// File: rtl/msixcap_rescan.sv
module msixcap_rescan
  import msixcap_pkg::*;
#(
  parameter int       NUM_VEC  = 8,
  parameter int       BAR_IDX  = 0,
  parameter bit [7:0] NEXT_PTR = 8'h00,
  parameter bit [7:0] CAP_ID   = 8'h11,
  localparam int      VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [3:0]         wr_off,
  input  logic [2:0]         wr_len,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         rd_sel,
  output logic [31:0]        rd_data,
  input  logic [NUM_VEC-1:0] vec_pending,
  input  logic [NUM_VEC-1:0] vec_masked,
  output logic               msix_enable,
  output logic               func_mask,
  output logic               scan_busy,
  output logic               deliver_req,
  output logic [VEC_W-1:0]   deliver_vec
);
  logic       hi_we;
  logic [7:0] hi_byte;
  logic       scan_trig;

  msixcap_wr_lanes #(.OFF_W(4), .LEN_W(3)) u_lanes (
    .wr_en   (wr_en),
    .wr_off  (wr_off),
    .wr_len  (wr_len),
    .wr_data (wr_data),
    .hi_we   (hi_we),
    .hi_byte (hi_byte)
  );

  msixcap_ctrl_reg #(
    .NUM_VEC (NUM_VEC),
    .BAR_IDX (BAR_IDX),
    .NEXT_PTR(NEXT_PTR),
    .CAP_ID  (CAP_ID)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hi_we    (hi_we),
    .hi_byte  (hi_byte),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .enable   (msix_enable),
    .fmask    (func_mask),
    .scan_trig(scan_trig)
  );

  msixcap_scan #(.NUM_VEC(NUM_VEC)) u_scan (
    .clk    (clk),
    .rst    (rst),
    .trig   (scan_trig),
    .pend   (vec_pending),
    .vmask  (vec_masked),
    .busy   (scan_busy),
    .del_req(deliver_req),
    .del_vec(deliver_vec)
  );
endmodule

// File: rtl/msixcap_rescan_chk.sv
module msixcap_rescan_chk #(
  parameter int  NUM_VEC = 8,
  localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             msix_enable,
  input logic             func_mask,
  input logic             scan_busy,
  input logic             deliver_req,
  input logic [VEC_W-1:0] deliver_vec
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!scan_busy && !deliver_req && !msix_enable && !func_mask));

  assert_no_write_no_change_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(msix_enable) && $stable(func_mask)));

  assert_unmask_starts_scan_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(func_mask) |-> scan_busy);

  assert_enable_starts_scan_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(msix_enable) |-> scan_busy);

  assert_vec_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    deliver_req |-> (32'(deliver_vec) < NUM_VEC));

  assert_req_follows_busy_R9: assert property (@(posedge clk) disable iff (rst)
    deliver_req |-> $past(scan_busy));

  assert_ascending_order_R9: assert property (@(posedge clk) disable iff (rst)
    (deliver_req && $past(deliver_req)) |->
      ((32'(deliver_vec) == 32'($past(deliver_vec)) + 1) ||
       (deliver_vec == '0 && 32'($past(deliver_vec)) == NUM_VEC - 1)));
endmodule

bind msixcap_rescan msixcap_rescan_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .msix_enable(msix_enable),
  .func_mask  (func_mask),
  .scan_busy  (scan_busy),
  .deliver_req(deliver_req),
  .deliver_vec(deliver_vec)
);

// File: tb/test_msixcap_rescan.sv
module test_msixcap_rescan;
  localparam int NV    = 6;
  localparam int BAR   = 3;
  localparam int VW    = $clog2(NV);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_off = '0;
  logic [2:0]    wr_len = '0;
  logic [31:0]   wr_data = '0;
  logic [1:0]    rd_sel = '0;
  logic [31:0]   rd_data;
  logic [NV-1:0] vec_pending = '0;
  logic [NV-1:0] vec_masked = '0;
  logic          msix_enable, func_mask, scan_busy, deliver_req;
  logic [VW-1:0] deliver_vec;

  int checks = 0;
  int failures = 0;
  int busy_n;
  int seq_n;
  int seq[16];

  always #4 clk = ~clk;

  msixcap_rescan #(.NUM_VEC(NV), .BAR_IDX(BAR), .NEXT_PTR(8'h40)) i_msixcap_rescan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .vec_pending(vec_pending), .vec_masked(vec_masked),
    .msix_enable(msix_enable), .func_mask(func_mask), .scan_busy(scan_busy),
    .deliver_req(deliver_req), .deliver_vec(deliver_vec)
  );

  // {offset, length, data, expected enable, expected mask}
  localparam int NT = 12;
  localparam logic [40:0] TBL [NT] = '{
    {4'd3,  3'd1, 32'h0000_00C0, 1'b1, 1'b1},
    {4'd3,  3'd1, 32'h0000_003F, 1'b0, 1'b0},
    {4'd0,  3'd4, 32'h40FF_FFFF, 1'b0, 1'b1},
    {4'd2,  3'd2, 32'h0000_8000, 1'b1, 1'b0},
    {4'd0,  3'd3, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {4'd4,  3'd4, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {4'd1,  3'd3, 32'h00C0_0000, 1'b1, 1'b1},
    {4'd3,  3'd4, 32'h0000_0000, 1'b0, 1'b0},
    {4'd1,  3'd2, 32'h0000_FFFF, 1'b0, 1'b0},
    {4'd3,  3'd2, 32'h0000_FFC0, 1'b1, 1'b1},
    {4'd11, 3'd4, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {4'd3,  3'd1, 32'h0000_0080, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_len = len; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic scan_run(input logic [7:0] b0, input int inj_at, input logic [7:0] b1);
    busy_n = 0;
    seq_n  = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_off = 4'd3; wr_len = 3'd1; wr_data = {24'h0, b0};
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (scan_busy) busy_n++;
      if (deliver_req && seq_n < 16) begin
        seq[seq_n] = int'(deliver_vec);
        seq_n++;
      end
      if (j == inj_at) begin
        wr_en = 1'b1; wr_data = {24'h0, b1};
      end
    end
    wr_en = 1'b0;
  endtask

  task automatic chk_seq(input string req, input int passes);
    chk(req, 32'(seq_n), 32'(3 * passes));
    for (int p = 0; p < passes; p++) begin
      if (seq_n >= 3 * (p + 1)) begin
        chk(req, 32'(seq[3*p]),   32'd0);
        chk(req, 32'(seq[3*p+1]), 32'd3);
        chk(req, 32'(seq[3*p+2]), 32'd5);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 enable", 32'(msix_enable), 0);
    chk("R1 mask", 32'(func_mask), 0);
    chk("R1 busy", 32'(scan_busy), 0);
    chk("R1 deliver", 32'(deliver_req), 0);

    // R2 R3 read-back of fixed fields
    do_read(2'd0, v);
    chk("R2 dword0", v, 32'h0005_4011);
    do_read(2'd1, v);
    chk("R3 table dword", v, 32'h0000_0003);
    do_read(2'd2, v);
    chk("R3 pba dword", v, 32'h0000_0063);
    do_read(2'd3, v);
    chk("R3 unused dword", v, 32'h0);

    // R4 R5 R6 write vector table
    for (int k = 0; k < NT; k++) begin
      do_write(TBL[k][40:37], TBL[k][36:34], TBL[k][33:2]);
      chk("R6 enable", 32'(msix_enable), 32'(TBL[k][1]));
      chk("R5 mask", 32'(func_mask), 32'(TBL[k][0]));
      repeat (8) @(negedge clk);
    end
    // R4 read-only fields unchanged after the table writes
    do_read(2'd0, v);
    chk("R4 dword0", v, 32'h8005_4011);
    do_read(2'd1, v);
    chk("R4 table dword", v, 32'h0000_0003);
    do_read(2'd2, v);
    chk("R4 pba dword", v, 32'h0000_0063);

    // scans: vectors 0,3,5 deliverable, 2 pending but masked
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    vec_pending = 6'b101101;
    vec_masked  = 6'b000100;

    scan_run(8'hC0, -1, 8'h00);           // R8 enable rise
    chk("R8 busy cycles", 32'(busy_n), 32'd6);
    chk_seq("R9 order", 1);
    scan_run(8'h80, -1, 8'h00);           // R7 mask fall
    chk("R7 busy cycles", 32'(busy_n), 32'd6);
    chk_seq("R7 deliveries", 1);
    scan_run(8'h80, -1, 8'h00);           // no change
    chk("R8 no-change no scan", 32'(busy_n), 32'd0);
    chk("R8 no-change no deliver", 32'(seq_n), 32'd0);
    scan_run(8'h40, -1, 8'h00);           // enable off, mask on
    chk("R8 disable no scan", 32'(busy_n), 32'd0);

    scan_run(8'hC0, 2, 8'h80);            // R10 mid-scan trigger
    chk("R10 mid restart busy", 32'(busy_n), 32'd12);
    chk_seq("R10 mid restart seq", 2);

    do_write(4'd3, 3'd1, 32'h40);
    scan_run(8'hC0, 5, 8'h80);            // R10 trigger on last vector
    chk("R10 last restart busy", 32'(busy_n), 32'd12);
    chk_seq("R10 last restart seq", 2);

    // R1 reset during scan
    do_write(4'd3, 3'd1, 32'h40);
    do_write(4'd3, 3'd1, 32'hC0);
    chk("R1 scan running", 32'(scan_busy), 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 busy after reset", 32'(scan_busy), 0);
    chk("R1 enable after reset", 32'(msix_enable), 0);
    chk("R1 deliver after reset", 32'(deliver_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule